// File: doc/BRIEF.md
# UART Receive Character Store with Error Tags

This block sits between a UART receiver and the host side. Each received character is written with its eight data bits and three per-character error tags: framing, parity and break. A character that carries errors is stored like any other, so the host reads each error next to the data it belongs to. The host sees the oldest stored entry on a fall-through output. Each host read removes that entry.

A runtime enable sets the capacity to the full depth, 16 entries by default, or to a single holding register. Changing the enable empties the storage. A character that arrives with no room for it is dropped, and a sticky overrun flag is raised. The flag stays set until the host clears it.

Top module: `uart_rx_fifo`

## Requirements
- R1: An entry is 11 bits. Bits 7:0 are the data, bit 8 is the framing-error tag, bit 9 is the parity-error tag and bit 10 is the break tag. A character with any tag set is stored and returned unchanged.
- R2: With `fifo_en_i` high, up to DEPTH (16) entries are held and read out oldest first. `level_o` gives the number held.
- R3: `empty_o` is high when no entry is held. `full_o` is high when the held count equals the current capacity.
- R4: A read while empty has no effect. A simultaneous write and read while not empty leaves `level_o` unchanged and advances the head.
- R5: A write while full with no read in the same cycle is discarded, leaving the stored entries untouched, and sets `overrun_o`. A write and a read together while full are both carried out, and no overrun is raised.
- R6: `overrun_o` stays set until `ovr_clr_i` is asserted. If a new overrun and a clear fall in the same cycle, the flag ends up set.
- R7: With `fifo_en_i` low, the capacity is one entry.
- R8: In a cycle where `fifo_en_i` differs from its value in the previous cycle, all entries are dropped. Any read or write in that cycle is ignored. `overrun_o` keeps its value.
- R9: After reset the block is empty, not full, `level_o` is 0 and `overrun_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1: capacity DEPTH, 0: single holding register |
| wr_en_i | input | 1 | Receiver delivers a character |
| wr_data_i | input | 8 | Received data bits |
| wr_frame_err_i | input | 1 | Framing error tag |
| wr_par_err_i | input | 1 | Parity error tag |
| wr_brk_err_i | input | 1 | Break tag |
| rd_en_i | input | 1 | Host removes the head entry |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rd_entry_o | output | 11 | Head entry {break, parity, framing, data} |
| empty_o | output | 1 | No entry held |
| full_o | output | 1 | Held count equals capacity |
| overrun_o | output | 1 | Sticky overrun flag |
| level_o | output | 5 | Number of entries held |

## Verification
Each write, read, clear or enable change acts at one clock edge. Every output that depends on it (`level_o`, `empty_o`, `full_o`, `overrun_o` and the fall-through head `rd_entry_o`) is updated right after that edge. No output needs a second cycle. The bench changes inputs on the falling edge, lets one rising edge pass, and samples all outputs at the next falling edge. Each result is therefore read exactly in the cycle it is due. The head entry is compared only when the expected state is not empty.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned TAG_W   = 3;
  localparam int unsigned ENTRY_W = DATA_W + TAG_W;

  // bit 10 break, bit 9 parity, bit 8 framing, bits 7:0 data
  typedef struct packed {
    logic              brk;
    logic              par;
    logic              frm;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             wr_req_i,
  input  logic             rd_req_i,
  output logic             push_o,
  output logic             ovr_evt_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] level_o,
  output logic             empty_o,
  output logic             full_o
);
  logic             fen_q;
  logic             flush;
  logic             pop;
  logic [CNT_W-1:0] cap;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] wptr_q, rptr_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                            input logic [CNT_W-1:0] c);
    if (CNT_W'(p) == c - CNT_W'(1)) return '0;
    return p + PTR_W'(1);
  endfunction

  assign flush     = fifo_en_i != fen_q;
  assign cap       = fifo_en_i ? CNT_W'(DEPTH) : CNT_W'(1);
  assign empty_o   = cnt_q == '0;
  assign full_o    = cnt_q == cap;
  assign pop       = rd_req_i && !empty_o && !flush;
  assign push_o    = wr_req_i && !flush && (!full_o || pop);
  assign ovr_evt_o = wr_req_i && !flush && full_o && !pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fen_q  <= 1'b1;
      cnt_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      fen_q <= fifo_en_i;
      if (flush) begin
        cnt_q  <= '0;
        wptr_q <= '0;
        rptr_q <= '0;
      end else begin
        if (push_o) wptr_q <= bump(wptr_q, cap);
        if (pop)    rptr_q <= bump(rptr_q, cap);
        case ({push_o, pop})
          2'b10:   cnt_q <= cnt_q + CNT_W'(1);
          2'b01:   cnt_q <= cnt_q - CNT_W'(1);
          default: cnt_q <= cnt_q;
        endcase
      end
    end
  end

  assign wr_ptr_o = wptr_q;
  assign rd_ptr_o = rptr_q;
  assign level_o  = cnt_q;
endmodule

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  rx_entry_t        wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output rx_entry_t        rdata_o
);
  rx_entry_t mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i == PTR_W'(g)) mem[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = mem[0];
    for (int i = 0; i < DEPTH; i++) begin
      if (raddr_i == PTR_W'(i)) rdata_o = mem[i];
    end
  end
endmodule

// File: rtl/rx_ovr_flag.sv
module rx_ovr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // set beats clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_en_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               wr_frame_err_i,
  input  logic               wr_par_err_i,
  input  logic               wr_brk_err_i,
  input  logic               rd_en_i,
  input  logic               ovr_clr_i,
  output logic [ENTRY_W-1:0] rd_entry_o,
  output logic               empty_o,
  output logic               full_o,
  output logic               overrun_o,
  output logic [CNT_W-1:0]   level_o
);
  logic             push, ovr_evt;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  rx_entry_t        wr_entry, head;

  assign wr_entry = '{brk: wr_brk_err_i, par: wr_par_err_i,
                      frm: wr_frame_err_i, data: wr_data_i};

  rx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_en_i (fifo_en_i),
    .wr_req_i  (wr_en_i),
    .rd_req_i  (rd_en_i),
    .push_o    (push),
    .ovr_evt_o (ovr_evt),
    .wr_ptr_o  (wr_ptr),
    .rd_ptr_o  (rd_ptr),
    .level_o   (level_o),
    .empty_o   (empty_o),
    .full_o    (full_o)
  );

  rx_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (push),
    .waddr_i (wr_ptr),
    .wdata_i (wr_entry),
    .raddr_i (rd_ptr),
    .rdata_o (head)
  );

  rx_ovr_flag u_ovr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovr_evt),
    .clr_i  (ovr_clr_i),
    .flag_o (overrun_o)
  );

  assign rd_entry_o = head;
endmodule

// File: rtl/rx_fifo_chk.sv
module rx_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic             ovr_clr_i,
  input logic [10:0]      rd_entry_o,
  input logic             empty_o,
  input logic             full_o,
  input logic             overrun_o,
  input logic [CNT_W-1:0] level_o
);
  logic fen_prev;
  logic same;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fen_prev <= 1'b1;
    else         fen_prev <= fifo_en_i;
  end
  assign same = fifo_en_i == fen_prev;

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CNT_W'(DEPTH)); // R2
  AST_PUSH_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    same && wr_en_i && !rd_en_i && !full_o |=> level_o == $past(level_o) + CNT_W'(1)); // R2
  AST_RD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    same && rd_en_i && !wr_en_i && empty_o |=> level_o == '0); // R4
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    same && wr_en_i && full_o && !rd_en_i |=> overrun_o); // R5
  AST_HEAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    same && !empty_o && !rd_en_i |=> $stable(rd_entry_o)); // R5
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !ovr_clr_i |=> overrun_o); // R6
  AST_ONE_DEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i && same |-> level_o <= CNT_W'(1)); // R7
  AST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !same |=> level_o == '0); // R8
endmodule

bind uart_rx_fifo rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fifo_en_i  (fifo_en_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .ovr_clr_i  (ovr_clr_i),
  .rd_entry_o (rd_entry_o),
  .empty_o    (empty_o),
  .full_o     (full_o),
  .overrun_o  (overrun_o),
  .level_o    (level_o)
);

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fen = 1'b1, wr = 1'b0, rd = 1'b0, clr = 1'b0;
  logic [10:0] wd = '0;
  logic [10:0] head;
  logic        emp, ful, ovr;
  logic [4:0]  lvl;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  uart_rx_fifo dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fen), .wr_en_i(wr),
    .wr_data_i(wd[7:0]), .wr_frame_err_i(wd[8]), .wr_par_err_i(wd[9]),
    .wr_brk_err_i(wd[10]), .rd_en_i(rd), .ovr_clr_i(clr),
    .rd_entry_o(head), .empty_o(emp), .full_o(ful), .overrun_o(ovr),
    .level_o(lvl)
  );

  typedef struct packed {
    logic fen; logic wr; logic [10:0] wd; logic rd; logic clr;
    logic [4:0] lvl; logic emp; logic ful; logic ovr; logic [10:0] head;
  } vec_t;

  // R1 tags: bit10 break, bit9 parity, bit8 framing
  localparam vec_t VECS [9] = '{
    '{1'b1, 1'b1, 11'h0A5, 1'b0, 1'b0, 5'd1, 1'b0, 1'b0, 1'b0, 11'h0A5},
    '{1'b1, 1'b1, 11'h400, 1'b0, 1'b0, 5'd2, 1'b0, 1'b0, 1'b0, 11'h0A5},
    '{1'b1, 1'b1, 11'h3C3, 1'b1, 1'b0, 5'd2, 1'b0, 1'b0, 1'b0, 11'h400},
    '{1'b1, 1'b0, 11'h000, 1'b1, 1'b0, 5'd1, 1'b0, 1'b0, 1'b0, 11'h3C3},
    '{1'b1, 1'b0, 11'h000, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 11'h000},
    '{1'b1, 1'b0, 11'h000, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 11'h000},
    '{1'b1, 1'b1, 11'h17E, 1'b0, 1'b0, 5'd1, 1'b0, 1'b0, 1'b0, 11'h17E},
    '{1'b1, 1'b1, 11'h055, 1'b1, 1'b0, 5'd1, 1'b0, 1'b0, 1'b0, 11'h055},
    '{1'b1, 1'b0, 11'h000, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 11'h000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs set at negedge, one rising edge, sample at next negedge
  task automatic step(input logic f, input logic w, input logic [10:0] d,
                      input logic r, input logic c);
    fen = f; wr = w; wd = d; rd = r; clr = c;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; clr = 1'b0;
  endtask

  function automatic logic [10:0] ent(input int i);
    return {3'(i % 8), 8'(8'h10 + i)};
  endfunction

  initial begin
    #(4 * 20000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 level", 32'(lvl), 0);
    chk("R9 empty", 32'(emp), 1);
    chk("R9 full", 32'(ful), 0);
    chk("R9 overrun", 32'(ovr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 table
    foreach (VECS[k]) begin
      step(VECS[k].fen, VECS[k].wr, VECS[k].wd, VECS[k].rd, VECS[k].clr);
      chk("R2 level", 32'(lvl), 32'(VECS[k].lvl));
      chk("R3 empty", 32'(emp), 32'(VECS[k].emp));
      chk("R3 full", 32'(ful), 32'(VECS[k].ful));
      chk("R5 overrun", 32'(ovr), 32'(VECS[k].ovr));
      if (!VECS[k].emp) chk("R1 head", 32'(head), 32'(VECS[k].head));
    end

    // R2 R3 fill to DEPTH
    for (int i = 0; i < 16; i++) step(1, 1, ent(i), 0, 0);
    chk("R3 full at 16", 32'(ful), 1);
    chk("R2 level 16", 32'(lvl), 16);
    // R5 write while full is dropped
    step(1, 1, 11'h7FF, 0, 0);
    chk("R5 overrun set", 32'(ovr), 1);
    chk("R5 level kept", 32'(lvl), 16);
    for (int i = 0; i < 16; i++) begin
      chk("R2 order", 32'(head), 32'(ent(i)));
      step(1, 0, 0, 1, 0);
    end
    chk("R5 no extra entry", 32'(emp), 1);
    chk("R6 sticky", 32'(ovr), 1);
    step(1, 0, 0, 0, 1);
    chk("R6 cleared", 32'(ovr), 0);

    // R5 write+read while full
    for (int i = 0; i < 16; i++) step(1, 1, ent(i), 0, 0);
    step(1, 1, 11'h123, 1, 0);
    chk("R5 full wr+rd level", 32'(lvl), 16);
    chk("R5 full wr+rd no ovr", 32'(ovr), 0);
    chk("R5 full wr+rd head", 32'(head), 32'(ent(1)));
    // R6 set beats clear
    step(1, 1, 11'h001, 0, 1);
    chk("R6 set wins", 32'(ovr), 1);
    step(1, 0, 0, 0, 1);
    chk("R6 clear", 32'(ovr), 0);

    // R8 flush on switch, write ignored
    step(0, 1, 11'h222, 0, 0);
    chk("R8 flush level", 32'(lvl), 0);
    chk("R8 flush empty", 32'(emp), 1);

    // R7 single holding register
    step(0, 1, 11'h2AB, 0, 0);
    chk("R7 full at 1", 32'(ful), 1);
    chk("R7 head", 32'(head), 11'h2AB);
    step(0, 1, 11'h0CD, 0, 0);
    chk("R7 overrun", 32'(ovr), 1);
    chk("R7 head kept", 32'(head), 11'h2AB);
    chk("R7 level 1", 32'(lvl), 1);
    step(0, 1, 11'h0EF, 1, 0);
    chk("R7 wr+rd head", 32'(head), 11'h0EF);
    step(0, 0, 0, 1, 0);
    chk("R7 drained", 32'(emp), 1);
    step(0, 1, 11'h111, 0, 0);
    chk("R7 one held", 32'(lvl), 1);

    // R8 switch back flushes, overrun unaffected
    step(1, 0, 0, 1, 0);
    chk("R8 flush back", 32'(lvl), 0);
    chk("R8 overrun kept", 32'(ovr), 1);
    step(1, 1, 11'h044, 0, 0);
    step(1, 1, 11'h055, 0, 0);
    chk("R2 capacity restored", 32'(ful), 0);
    chk("R2 level 2", 32'(lvl), 2);
    chk("R2 head", 32'(head), 11'h044);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule